// File: doc/BRIEF.md
# Legacy Memory Attribute and Row Decoder

This block sits in the host address path of a memory controller. Each cycle a request may present a host byte address and a read/write flag. The block decides whether the access is served by DRAM or forwarded to memory-mapped I/O, and it names the DRAM row the address falls in. The answer is registered and appears one cycle later together with a response-valid flag.

Three configuration inputs steer the decode. Seven attribute bytes grant DRAM access by direction in the legacy region between 768 KB and 1 MB. Eight row-top bytes give the cumulative end of rows 0..7 in 8 MB units. A 2-bit hole selector can carve one fixed window out of DRAM. An address at or above the last row top is flagged as out of range and goes to I/O.

Top module: `legacy_mem_router`

## Requirements
- R1: While reset is held and after it is released, before any request, rspValid, toDram, toMmio, outOfRange and rowIdx are all 0.
- R2: A request with reqValid=1 at a rising edge is answered at that edge (rspValid=1 after it). In a cycle with reqValid=0, rspValid goes to 0 and the other outputs keep their values.
- R3: With rspValid=1, exactly one of toDram and toMmio is 1.
- R4: rowIdx is the lowest i in 0..7 for which byte i of rowTop (bits 8i+7:8i) is greater than reqAddr[31:23].
- R5: A row whose top equals the top of the row below it is empty and is never reported in rowIdx.
- R6: When no row top exceeds reqAddr[31:23], outOfRange=1, toMmio=1 and rowIdx=0. This includes the case where all row tops are 0.
- R7: In a legacy segment, a 2-bit attribute of 00 sends all accesses to I/O. 01 sends reads to DRAM and writes to I/O. 10 sends writes to DRAM and reads to I/O. 11 sends both to DRAM. Outside the legacy region and outside holes, in-range addresses go to DRAM.
- R8: 0xF0000..0xFFFFF is one segment governed by attrBytes[5:4]. attrBytes[3:0] has no effect.
- R9: 0xC0000..0xEFFFF is twelve 16 KB segments numbered s=0..11 upward. Segment s uses attribute byte k=1+s/2 (bits 8k+7:8k): bits [1:0] when s is even and bits [5:4] when s is odd. Bits [3:2] and [7:6] of those bytes have no effect.
- R10: holeSel=01 sends 0x80000..0x9FFFF to I/O whatever the attributes are. holeSel=00 carves no hole.
- R11: holeSel=10 sends 0xF00000..0xFFFFFF to I/O. holeSel=11 carves no hole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Host byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| attrBytes | input | 56 | Seven legacy attribute bytes, byte k at bits 8k+7:8k |
| rowTop | input | 64 | Eight cumulative row tops in 8 MB units, row i at bits 8i+7:8i |
| holeSel | input | 2 | Fixed hole selector |
| rspValid | output | 1 | Registered response valid |
| toDram | output | 1 | Access served by DRAM |
| toMmio | output | 1 | Access forwarded to memory-mapped I/O |
| rowIdx | output | 3 | Selected DRAM row |
| outOfRange | output | 1 | Address at or above the last row top |

## Verification
The bench sweeps every legacy segment in both directions under rotating attribute patterns, with junk in the reserved bits. A decoder that swapped the nibble used for a segment pair would misroute half the segments, and one that mixed up the direction bits would swap reads and writes. Row sweeps cross each 8 MB step with two empty rows in the table. A strict-versus-inclusive comparison error would shift rowIdx at every boundary, and a bad priority would land on an empty row. Hole tests probe the first and last byte of each window under all four selector codes, so an off-by-one edge or a reserved code that is treated as a hole shows up as a wrong route.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  // Strobes handed from the control decode to the registered datapath.
  typedef struct packed {
    logic capture;     // accept the present request
    logic legacyHit;   // address lies in an attribute-controlled segment
    logic legacyAllow; // that segment's attribute grants DRAM for this direction
    logic holeHit;     // address lies in the enabled fixed hole
  } lmr_strobe_t;
endpackage

// File: rtl/lmr_control.sv
module lmr_control
  import lmr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_N = 7
) (
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic [ATTR_N*8-1:0] attrBytes,
  input  logic [1:0]          holeSel,
  output lmr_strobe_t         strobe
);
  localparam int SEG_N     = 2 * (ATTR_N - 1);
  localparam int SEG_IDX_W = $clog2(SEG_N);

  logic [1:0] segAttr [SEG_N];

  // each byte after the first serves two 16 KB segments
  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    localparam int LSB = 8 * (1 + s / 2) + ((s % 2) != 0 ? 4 : 0);
    assign segAttr[s] = attrBytes[LSB +: 2];
  end

  logic                 below1M, topSeg, midSeg;
  logic [SEG_IDX_W-1:0] segIdx;
  logic [1:0]           midAttr, attrSel;
  logic                 holeLow, holeHigh;

  assign below1M = (reqAddr >> 20) == '0;
  assign topSeg  = below1M && (reqAddr[19:16] == 4'hF);
  assign midSeg  = below1M && (reqAddr[19:18] == 2'b11) && !topSeg;
  assign segIdx  = reqAddr[14 +: SEG_IDX_W];

  always_comb begin
    midAttr = 2'b00;
    for (int s = 0; s < SEG_N; s++) begin
      if (segIdx == SEG_IDX_W'(s)) midAttr = segAttr[s];
    end
  end

  assign attrSel  = topSeg ? attrBytes[5:4] : midAttr;
  assign holeLow  = (holeSel == 2'b01) && ((reqAddr >> 17) == ADDR_W'(4));
  assign holeHigh = (holeSel == 2'b10) && ((reqAddr >> 20) == ADDR_W'(15));

  assign strobe.capture     = reqValid;
  assign strobe.legacyHit   = topSeg || midSeg;
  assign strobe.legacyAllow = reqWrite ? attrSel[1] : attrSel[0];
  assign strobe.holeHit     = holeLow || holeHigh;

  logic unusedCtl;
  assign unusedCtl = ^{reqAddr[13:0], attrBytes[3:0], attrBytes[7:6]};
endmodule

// File: rtl/lmr_datapath.sv
module lmr_datapath
  import lmr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ROWS       = 8,
  parameter int BOUND_W    = 8,
  parameter int GRAN_SHIFT = 23
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  lmr_strobe_t                strobe,
  input  logic [ADDR_W-GRAN_SHIFT-1:0] addrHi,
  input  logic [ROWS*BOUND_W-1:0]    rowTop,
  output logic                       rspValid,
  output logic                       toDram,
  output logic                       toMmio,
  output logic [$clog2(ROWS)-1:0]    rowIdx,
  output logic                       outOfRange
);
  localparam int SLICE_W = ADDR_W - GRAN_SHIFT;
  localparam int ROW_W   = $clog2(ROWS);

  logic [ROWS-1:0] above;
  for (genvar i = 0; i < ROWS; i++) begin : g_cmp
    assign above[i] = SLICE_W'(rowTop[i*BOUND_W +: BOUND_W]) > addrHi;
  end

  logic [ROW_W-1:0] rowNext;
  logic             oorNext, dramNext;

  always_comb begin
    rowNext = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (above[i]) rowNext = ROW_W'(i);
    end
  end

  assign oorNext  = ~|above;
  assign dramNext = !oorNext && !strobe.holeHit &&
                    (!strobe.legacyHit || strobe.legacyAllow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      toDram     <= 1'b0;
      toMmio     <= 1'b0;
      rowIdx     <= '0;
      outOfRange <= 1'b0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) begin
        toDram     <= dramNext;
        toMmio     <= !dramNext;
        rowIdx     <= rowNext;
        outOfRange <= oorNext;
      end
    end
  end

  function automatic logic [SLICE_W-1:0] boundAt(input logic [ROWS*BOUND_W-1:0] v,
                                                 input logic [ROW_W-1:0] idx);
    return SLICE_W'(v[idx*BOUND_W +: BOUND_W]);
  endfunction

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rspValid);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !rspValid && $stable(toDram) && $stable(toMmio)
                        && $stable(rowIdx) && $stable(outOfRange));
  a_r3_one_route: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (toDram ^ toMmio));
  a_r6_oor_to_mmio: assert property (@(posedge clk) disable iff (!rstN)
    outOfRange |-> toMmio && rowIdx == '0);
  a_r4_row_above: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !outOfRange |-> boundAt($past(rowTop), rowIdx) > $past(addrHi));
  a_r5_lower_not_above: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !outOfRange && rowIdx != '0 |->
      boundAt($past(rowTop), rowIdx - 1'b1) <= $past(addrHi));
endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
  import lmr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ATTR_N     = 7,
  parameter int ROWS       = 8,
  parameter int BOUND_W    = 8,
  parameter int GRAN_SHIFT = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    reqWrite,
  input  logic [ATTR_N*8-1:0]     attrBytes,
  input  logic [ROWS*BOUND_W-1:0] rowTop,
  input  logic [1:0]              holeSel,
  output logic                    rspValid,
  output logic                    toDram,
  output logic                    toMmio,
  output logic [$clog2(ROWS)-1:0] rowIdx,
  output logic                    outOfRange
);
  lmr_strobe_t strobe;

  lmr_control #(.ADDR_W(ADDR_W), .ATTR_N(ATTR_N)) u_ctl (
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .attrBytes(attrBytes), .holeSel(holeSel), .strobe(strobe)
  );

  lmr_datapath #(.ADDR_W(ADDR_W), .ROWS(ROWS), .BOUND_W(BOUND_W),
                 .GRAN_SHIFT(GRAN_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .addrHi(reqAddr[ADDR_W-1:GRAN_SHIFT]), .rowTop(rowTop),
    .rspValid(rspValid), .toDram(toDram), .toMmio(toMmio),
    .rowIdx(rowIdx), .outOfRange(outOfRange)
  );

  logic unusedTop;
  assign unusedTop = ^reqAddr[GRAN_SHIFT-1:0];
endmodule

// File: tb/legacy_mem_router_bench.sv
module legacy_mem_router_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [55:0] attrBytes = '0;
  logic [63:0] rowTop = '0;
  logic [1:0]  holeSel = 2'b00;
  logic        rspValid, toDram, toMmio, outOfRange;
  logic [2:0]  rowIdx;

  int checks = 0;
  int fails = 0;
  logic [7:0] attrB [7];
  logic [7:0] topB  [8];

  always #2 clk = ~clk;

  legacy_mem_router u_legacy_mem_router (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .attrBytes(attrBytes), .rowTop(rowTop),
    .holeSel(holeSel), .rspValid(rspValid), .toDram(toDram),
    .toMmio(toMmio), .rowIdx(rowIdx), .outOfRange(outOfRange)
  );

  task automatic packCfg();
    for (int k = 0; k < 7; k++) attrBytes[8*k +: 8] = attrB[k];
    for (int k = 0; k < 8; k++) rowTop[8*k +: 8] = topB[k];
  endtask

  task automatic refModel(input logic [31:0] a, input logic w,
                          output logic eD, output logic eO, output logic [2:0] eR);
    logic [1:0] at;
    logic allow, hole;
    int seg;
    int hi;
    hi = int'(a >> 23);
    eO = 1'b1; eR = 3'd0;
    for (int i = 0; i < 8; i++)
      if (eO && int'(topB[i]) > hi) begin eO = 1'b0; eR = 3'(i); end
    allow = 1'b1;
    if (a >= 32'hC0000 && a < 32'h100000) begin
      if (a >= 32'hF0000) at = attrB[0][5:4];
      else begin
        seg = int'((a - 32'hC0000) / 32'h4000);
        at = (seg % 2 == 1) ? attrB[1 + seg/2][5:4] : attrB[1 + seg/2][1:0];
      end
      allow = w ? at[1] : at[0];
    end
    hole = (holeSel == 2'd1 && a >= 32'h80000 && a < 32'hA0000) ||
           (holeSel == 2'd2 && a >= 32'hF00000 && a < 32'h1000000);
    eD = !eO && !hole && allow;
  endtask

  logic lastD, lastO;
  logic [2:0] lastR;

  task automatic issue(input logic [31:0] a, input logic w, input string tag);
    logic eD, eO;
    logic [2:0] eR;
    @(negedge clk);
    reqAddr = a; reqWrite = w; reqValid = 1'b1;
    refModel(a, w, eD, eO, eR);
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b1 || toDram !== eD || toMmio !== !eD ||
        outOfRange !== eO || rowIdx !== eR) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b: got v=%0b d=%0b m=%0b oor=%0b row=%0d exp v=1 d=%0b m=%0b oor=%0b row=%0d",
               tag, a, w, rspValid, toDram, toMmio, outOfRange, rowIdx,
               eD, !eD, eO, eR);
    end
    lastD = eD; lastO = eO; lastR = eR;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] holeAddr [8];
    holeAddr = '{32'h7FFFF, 32'h80000, 32'h9FFFF, 32'hA0000,
                 32'hEFFFFF, 32'hF00000, 32'hFFFFFF, 32'h1000000};
    for (int k = 0; k < 7; k++) attrB[k] = 8'h00;
    topB = '{8'd8, 8'd8, 8'd16, 8'd24, 8'd24, 8'd32, 8'd40, 8'd48};
    packCfg();
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (rspValid || toDram || toMmio || outOfRange || rowIdx != 0) begin
      fails++; $display("FAIL R1 in reset: got %0b%0b%0b%0b row=%0d exp 0000 row=0",
                        rspValid, toDram, toMmio, outOfRange, rowIdx);
    end
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    checks++;  // R1 after release, no request
    if (rspValid || toDram || toMmio || outOfRange || rowIdx != 0) begin
      fails++; $display("FAIL R1 idle: got %0b%0b%0b%0b row=%0d exp 0000 row=0",
                        rspValid, toDram, toMmio, outOfRange, rowIdx);
    end

    // R4 R5 R6 row sweep across every 8 MB step
    for (int g = 0; g < 64; g++) begin
      string tag;
      tag = (g >= 48) ? "R6" : ((g >= 8 && g < 16) || (g >= 24 && g < 32)) ? "R5" : "R4";
      issue((32'(g) << 23) | 32'h123400, g[0], tag);
      issue((32'(g) << 23) | 32'h7FFFFF, 1'b0, tag);
    end

    // R2 hold on idle cycle
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 32'hFFFF_FFFF;
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || toDram !== lastD || toMmio !== !lastD ||
        outOfRange !== lastO || rowIdx !== lastR) begin
      fails++; $display("FAIL R2 hold: got v=%0b d=%0b oor=%0b row=%0d exp v=0 d=%0b oor=%0b row=%0d",
                        rspValid, toDram, outOfRange, rowIdx, lastD, lastO, lastR);
    end

    // R7 R8 R9 legacy sweep with rotating attributes and junk in reserved bits
    for (int p = 0; p < 4; p++) begin
      attrB[0] = {2'b11, 2'((p + 3) % 4), 4'hA};
      for (int k = 1; k < 7; k++)
        attrB[k] = {2'b10, 2'((2*(k-1) + 1 + p) % 4), 2'b01, 2'((2*(k-1) + p) % 4)};
      packCfg();
      for (int s = 0; s < 16; s++) begin
        for (int w = 0; w < 2; w++) begin
          issue(32'hC0000 + 32'(s) * 32'h4000 + 32'h0123, w[0],
                (s >= 12) ? "R8" : (p == 0 ? "R7" : "R9"));
        end
      end
      issue(32'hBFFFF, 1'b1, "R7");
      issue(32'h100000, 1'b0, "R7");
    end

    // R10 R11 hole windows under every selector code
    attrB[0] = 8'h30;
    for (int k = 1; k < 7; k++) attrB[k] = 8'h33;
    packCfg();
    for (int h = 0; h < 4; h++) begin
      holeSel = 2'(h);
      for (int j = 0; j < 8; j++)
        issue(holeAddr[j], j[0], (j < 4) ? "R10" : "R11");
    end
    holeSel = 2'b00;

    // R6 empty table and R3 coverage
    for (int k = 0; k < 8; k++) topB[k] = 8'd0;
    packCfg();
    issue(32'h0, 1'b0, "R6");
    issue(32'h000F_0000, 1'b1, "R3");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule